// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block produces one pulse-width-modulated output from a system clock. The clock first passes through an 8-bit prescaler and a power-of-two divider to form a counting tick. A 16-bit counter then runs over a programmed period, and a duty value sets how long the output stays high in each period. Software programs the period and the duty through a plain write port. Each write goes into a holding (shadow) register and reaches the running counter only when the next period begins, so a period is never cut short or stretched by a write made during it.

The counter runs in one of two alignments. In edge alignment it counts down from the period value to zero, and the output is high for the last (duty+1) ticks of each period. In center alignment it counts up from zero to the period value, holds that value for one more tick, and counts back down to zero. The high pulse then sits symmetrically about the middle of the period. In either alignment the channel can run continuously, or run a single period and then stop until it is disabled and enabled again.

Top module: `pwm_timer_channel`

## Requirements
- R1: While reset is asserted and afterwards until the channel is enabled, `pwm_out` is 0.
- R2: In edge alignment (`align_center`=0), with period value P and duty value D < P, every period lasts P+1 ticks. The output is low for the first P-D ticks and high for the remaining D+1 ticks. The first period starts on the first tick after `enable` rises.
- R3: When the duty value is greater than or equal to the period value, `pwm_out` stays high for the whole period in both alignments.
- R4: A write made during a period does not change that period. The new period and duty values take effect from the next period start.
- R5: In center alignment (`align_center`=1), a period lasts 2*(P+1) ticks. The counter visits 0..P and then P..0. The output is high while count+D >= P, which gives 2*(D+1) high ticks centered on the period midpoint.
- R6: With `one_shot`=1 the channel runs exactly one period and then holds `pwm_out` low. Clearing and then setting `enable` starts one more period.
- R7: While `enable` is 0, `pwm_out` is 0 in that same cycle and the prescaler and divider are cleared. Enabling again starts a fresh period, with the first tick arriving exactly prescale+1 clocks after the enabling edge when the divider setting is 0.
- R8: A prescale value N gives a prescaler output every N+1 clocks, so the value 0 passes every clock through.
- R9: `div_sel` codes 0, 1, 2, 3 and 4 divide the prescaler output by 1, 2, 4, 8 and 16. Codes 5 to 7 also divide by 16.
- R10: When `wr_en`=1, `wr_data` goes to the period shadow register if `wr_sel`=0 and to the duty shadow register if `wr_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the channel; 0 holds output low and clears the tick chain |
| align_center | input | 1 | 0 = edge alignment, 1 = center alignment |
| one_shot | input | 1 | 1 = stop after one period, 0 = continuous |
| prescale | input | 8 | Prescaler value N; divides by N+1 |
| div_sel | input | 3 | Divider select code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = period register, 1 = duty register |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
With prescale 0 and divider code 0, the first tick falls on the first clock edge after `enable` is sampled high. The output then reflects the new count right after that edge, so the bench samples every clock at the falling edge and compares it with a per-position pattern worked out from P and D. With prescale 3, the output stays low through edge 6 after re-enabling, then goes high from edge 7 to edge 10. A write at a falling edge is captured on the next rising edge and shows up only in the following period, and the bench checks the whole of both periods. For prescaler and divider settings, the bench waits one full period and then counts high clocks over a window of two whole periods. That count equals 2*(D+1)*(N+1)*divide whatever the phase.

// File: rtl/pwm_timer_pkg.sv
// Package: shared definitions for the PWM timer channel.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_timer_pkg;

    // Count direction for the center-aligned sweep
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } count_dir_e;

    // Write-port register select codes
    localparam logic SEL_PERIOD = 1'b0;
    localparam logic SEL_DUTY   = 1'b1;

endpackage

// File: rtl/pwm_tick_gen.sv
// Module: pwm_tick_gen
// Builds the counting tick: a prescaler dividing by prescale+1, followed by a
// binary divider of 2**div_sel, saturating at 2**DIV_LOG2.
// Assumes: both stages are cleared whenever enable is low, so a restart
// always begins a full prescale interval.
module pwm_tick_gen #(
    parameter int PRE_W    = 8,
    parameter int SEL_W    = 3,
    parameter int DIV_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] prescale,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    logic [PRE_W-1:0]    pre_cnt;
    logic [DIV_LOG2-1:0] div_cnt;
    logic [DIV_LOG2-1:0] div_mask;
    logic                pre_hit;

    // Prescaler fires at its limit; >= recovers if prescale drops mid-count
    assign pre_hit = (pre_cnt >= prescale);

    // Mask of low divider bits that must all be set for a tick
    always_comb begin
        div_mask = '0;
        for (int i = 0; i < DIV_LOG2; i++) begin
            if (i < int'(div_sel)) begin
                div_mask[i] = 1'b1;
            end
        end
    end

    // Tick when the prescaler fires and the divider has reached its phase
    assign tick = enable && pre_hit && ((div_cnt & div_mask) == div_mask);

    // Advance the prescaler and the divider; clear both when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_hit) begin
            pre_cnt <= '0;
            div_cnt <= div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R7: a disabled channel leaves the tick chain cleared
    assert_chain_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pre_cnt == '0 && div_cnt == '0));

    // R8: an enabled prescaler never exceeds its limit while the limit holds
    assert_pre_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $stable(prescale) && pre_cnt <= prescale) |=> pre_cnt <= prescale);

endmodule

// File: rtl/pwm_shadow_regs.sv
// Module: pwm_shadow_regs
// Holds software-written period and duty values in shadow registers and
// copies them to the active registers on each period-start strobe.
// Assumes: a write in the same cycle as a load lands in the shadow only and
// is used from the period after.
module pwm_shadow_regs
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load,
    output logic [CNT_W-1:0] shadow_period,
    output logic [CNT_W-1:0] act_period,
    output logic [CNT_W-1:0] act_duty
);

    logic [CNT_W-1:0] shadow_duty;

    // Capture software writes into the selected shadow register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_period <= '0;
            shadow_duty   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_PERIOD) begin
                shadow_period <= wr_data;
            end else begin
                shadow_duty <= wr_data;
            end
        end
    end

    // Transfer shadows to the active set at each period start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= '0;
            act_duty   <= '0;
        end else if (load) begin
            act_period <= shadow_period;
            act_duty   <= shadow_duty;
        end
    end

    // R4: active values only move on a period-start strobe
    assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_period) && $stable(act_duty)));

endmodule

// File: rtl/pwm_count_core.sv
// Module: pwm_count_core
// Runs the period counter in edge (down) or center (up, hold, down) sweep,
// raises the load strobe at each period start, handles single-shot stop and
// compares the count with the duty to form the output.
// Assumes: tick is already gated by enable; active registers are written
// by the shadow block on the same edge the load strobe is high.
module pwm_count_core
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             align_center,
    input  logic             one_shot,
    input  logic [CNT_W-1:0] shadow_period,
    input  logic [CNT_W-1:0] act_period,
    input  logic [CNT_W-1:0] act_duty,
    output logic             load,
    output logic             pwm_out
);

    logic [CNT_W-1:0] cnt;
    count_dir_e       dir;
    logic             running;
    logic             done;
    logic             at_end;
    logic             stop;
    logic             cmp_hi;

    // Last tick of a period: zero in edge mode, zero on the way down in center
    assign at_end = running && (cnt == '0) && (!align_center || dir == DIR_DOWN);

    // Period start from idle, or a continuous reload at the end
    assign load = tick && ((!running && !done) || (at_end && !one_shot));
    assign stop = tick && at_end && one_shot;

    // Duty comparison for each alignment, widened to avoid wrap
    always_comb begin
        if (align_center) begin
            cmp_hi = ({1'b0, cnt} + {1'b0, act_duty}) >= {1'b0, act_period};
        end else begin
            cmp_hi = (cnt <= act_duty);
        end
    end

    // Output is forced low while disabled or idle
    assign pwm_out = enable && running && cmp_hi;

    // Sequence the counter through the period and handle start and stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            dir     <= DIR_DOWN;
            running <= 1'b0;
            done    <= 1'b0;
        end else if (!enable) begin
            running <= 1'b0;
            done    <= 1'b0;
        end else if (load) begin
            running <= 1'b1;
            dir     <= align_center ? DIR_UP : DIR_DOWN;
            cnt     <= align_center ? '0 : shadow_period;
        end else if (stop) begin
            running <= 1'b0;
            done    <= 1'b1;
        end else if (tick && running) begin
            if (align_center && dir == DIR_UP) begin
                if (cnt >= act_period) begin
                    dir <= DIR_DOWN;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R2: a running count stays within the active period value
    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cnt <= act_period);

    // R6: a finished single shot stays idle
    assert_shot_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);

    // R7: dropping enable ends the run on the next edge
    assert_disable_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!running && !done));

    // R3: duty at or above period keeps the running output high
    assert_full_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && running && act_duty >= act_period) |-> pwm_out);

endmodule

// File: rtl/pwm_timer_channel.sv
// Module: pwm_timer_channel (top)
// One double-buffered PWM timer: tick chain, shadow/active registers and the
// period counter with edge or center alignment and single-shot option.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module pwm_timer_channel #(
    parameter int CNT_W    = 16,
    parameter int PRE_W    = 8,
    parameter int SEL_W    = 3,
    parameter int DIV_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             align_center,
    input  logic             one_shot,
    input  logic [PRE_W-1:0] prescale,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out
);

    logic             tick;
    logic             load;
    logic [CNT_W-1:0] shadow_period;
    logic [CNT_W-1:0] act_period;
    logic [CNT_W-1:0] act_duty;

    pwm_tick_gen #(
        .PRE_W    (PRE_W),
        .SEL_W    (SEL_W),
        .DIV_LOG2 (DIV_LOG2)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .prescale (prescale),
        .div_sel  (div_sel),
        .tick     (tick)
    );

    pwm_shadow_regs #(
        .CNT_W (CNT_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .load          (load),
        .shadow_period (shadow_period),
        .act_period    (act_period),
        .act_duty      (act_duty)
    );

    pwm_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .tick          (tick),
        .align_center  (align_center),
        .one_shot      (one_shot),
        .shadow_period (shadow_period),
        .act_period    (act_period),
        .act_duty      (act_duty),
        .load          (load),
        .pwm_out       (pwm_out)
    );

    // R1: output is low in the cycle after any reset cycle
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> !pwm_out);

endmodule

// File: tb/pwm_timer_channel_bench.sv
module pwm_timer_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        align_center = 1'b0;
    logic        one_shot = 1'b0;
    logic [7:0]  prescale = '0;
    logic [2:0]  div_sel = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        pwm_out;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pwm_timer_channel u_pwm_timer_channel (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .align_center (align_center),
        .one_shot     (one_shot),
        .prescale     (prescale),
        .div_sel      (div_sel),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .pwm_out      (pwm_out)
    );

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: pwm_out=%b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_reg(input logic sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = 16'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        enable = 1'b0;
        repeat (n) step();
    endtask

    // One edge-aligned period: high once position p >= period-duty
    task automatic check_edge_period(input int per, input int duty, input string tag);
        for (int p = 0; p <= per; p++) begin
            step();
            check(pwm_out, (p >= per - duty), tag);
        end
    endtask

    // One center-aligned period: value sweeps 0..per, per..0
    task automatic check_center_period(input int per, input int duty, input string tag);
        for (int q = 0; q < 2 * (per + 1); q++) begin
            int v;
            v = (q <= per) ? q : (2 * per + 1 - q);
            step();
            check(pwm_out, (v + duty >= per), tag);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) step();
        check(pwm_out, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check(pwm_out, 1'b0, "R1 after reset");
        end
    endtask

    task automatic test_edge();
        align_center = 1'b0; one_shot = 1'b0; prescale = 0; div_sel = 0;
        write_reg(1'b0, 9);                 // R10 period
        write_reg(1'b1, 3);                 // R10 duty
        enable = 1'b1;
        check_edge_period(9, 3, "R2");
        check_edge_period(9, 3, "R2");
        idle(3);
        write_reg(1'b0, 3);
        write_reg(1'b1, 3);
        enable = 1'b1;
        check_edge_period(3, 3, "R3 edge duty=period");
        idle(3);
        write_reg(1'b1, 200);
        enable = 1'b1;
        check_edge_period(3, 200, "R3 edge duty>period");
        idle(3);
    endtask

    task automatic test_shadow();
        write_reg(1'b0, 9);
        write_reg(1'b1, 3);
        enable = 1'b1;
        for (int p = 0; p <= 9; p++) begin
            step();
            check(pwm_out, (p >= 6), "R4 current period unchanged");
            if (p == 3) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'd2; end
            if (p == 4) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'd5; end
            if (p == 5) wr_en = 1'b0;
        end
        check_edge_period(5, 2, "R4 new values next period");
        check_edge_period(5, 2, "R4 new values kept");
        idle(3);
    endtask

    task automatic test_center();
        align_center = 1'b1;
        write_reg(1'b0, 4);
        write_reg(1'b1, 1);
        enable = 1'b1;
        check_center_period(4, 1, "R5");
        check_center_period(4, 1, "R5");
        idle(3);
        write_reg(1'b1, 6);
        enable = 1'b1;
        check_center_period(4, 6, "R3 center full high");
        idle(3);
        align_center = 1'b0;
    endtask

    task automatic test_one_shot();
        one_shot = 1'b1;
        write_reg(1'b0, 3);
        write_reg(1'b1, 1);
        enable = 1'b1;
        check_edge_period(3, 1, "R6 single period");
        for (int i = 0; i < 8; i++) begin
            step();
            check(pwm_out, 1'b0, "R6 stopped");
        end
        idle(2);
        enable = 1'b1;
        check_edge_period(3, 1, "R6 restart");
        for (int i = 0; i < 4; i++) begin
            step();
            check(pwm_out, 1'b0, "R6 stopped again");
        end
        idle(3);
        one_shot = 1'b0;
    endtask

    task automatic test_disable();
        prescale = 8'd3; div_sel = 0;
        write_reg(1'b0, 1);
        write_reg(1'b1, 0);
        enable = 1'b1;
        repeat (9) step();                  // high phase: edges 7..10 after enable
        enable = 1'b0;
        #1;
        check(pwm_out, 1'b0, "R7 low at once");
        for (int i = 0; i < 3; i++) begin
            step();
            check(pwm_out, 1'b0, "R7 held low");
        end
        enable = 1'b1;
        for (int k = 0; k < 15; k++) begin
            step();
            check(pwm_out, (k >= 7 && k <= 10), "R7 R8 fresh restart timing");
        end
        idle(3);
    endtask

    // Counts high clocks over two whole periods after one settling period
    task automatic window(input int pre, input int sel, input string tag);
        int d;
        int per_clk;
        int highs;
        d = (sel >= 4) ? 16 : (1 << sel);
        per_clk = 4 * (pre + 1) * d;
        prescale = 8'(pre); div_sel = 3'(sel);
        @(negedge clk);
        enable = 1'b1;
        repeat (per_clk + (pre + 1) * d) step();
        highs = 0;
        for (int i = 0; i < 2 * per_clk; i++) begin
            step();
            if (pwm_out) highs++;
        end
        n_run++;
        if (highs != 2 * (pre + 1) * d) begin
            n_fail++;
            $display("FAIL %s: high clocks=%0d expected %0d", tag, highs, 2 * (pre + 1) * d);
        end
        idle(3);
    endtask

    task automatic test_dividers();
        write_reg(1'b0, 3);
        write_reg(1'b1, 0);
        window(0, 0, "R8 prescale 0");
        window(4, 0, "R8 prescale 4");
        window(0, 1, "R9 div 2");
        window(0, 2, "R9 div 4");
        window(0, 3, "R9 div 8");
        window(0, 4, "R9 div 16");
        window(0, 6, "R9 code 6 saturates");
        window(2, 2, "R8 R9 combined");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish (all requirements)");
        report();
        $finish;
    end

    initial begin
        test_reset();
        test_edge();
        test_shadow();
        test_center();
        test_one_shot();
        test_disable();
        test_dividers();
        report();
        $finish;
    end

endmodule